// File: doc/BRIEF.md
# Solenoid Peak-and-Hold Current Controller

This block drives the gate of a coil switch so that an inductive actuator first pulls in at a high current and then sits at a lower current that costs less power while held. Current is not set by a fixed duty. The block compares each sampled coil current against the target of the active phase and switches the gate with a hysteresis band. Minimum on and off times keep noise near a threshold from chattering the switch.

The pull-in phase ends at a programmed cycle count or at the first sample that reaches the pull-in threshold, whichever comes first. During normal off intervals the slow recirculation path is selected. When the coil is released or a fault occurs, the fast-decay path is selected so that the coil drops out quickly. A hard overcurrent limit latches a fault that holds the gate off until enable is raised again.

For diagnosis the block reports the largest current seen in each phase, the accumulated cycles spent with the gate pinned on, and the gate-on count over a fixed window as an effort figure.

Top module: `solenoid_pkhold_drv`

## Requirements
- R1: Phase code (0 idle, 1 pull-in, 2 hold) is 0 after reset. It becomes 1 at the first clock edge that samples enable high after enable was low. The gate stays low at that edge.
- R2: Pull-in moves to hold at the edge that samples a current at or above the pull-in threshold, or at the edge ending the programmed count of pull-in cycles (a count of 0 acts as 1). Hold persists while enable stays high.
- R3: With no fault, the gate rises when current plus HYST_BAND is below the phase target. It falls when current exceeds target plus HYST_BAND. Current exactly on either band edge causes no change.
- R4: Once raised, the gate stays high for at least MIN_ON cycles, and once lowered stays low for at least MIN_OFF cycles, unless a disable or fault forces it low.
- R5: At the first edge that samples enable low, the gate goes low and the phase returns to 0.
- R6: A sample above OC_LIMIT while enabled drives the gate low at that edge and sets the fault flag. The flag and the gate block hold through enable low, and clear only at the next enable rising edge.
- R7: The fast-decay select output is 1 (fast) after reset, while disabled and while the fault flag is set, and 0 (slow recirculation) otherwise.
- R8: The saturation counter adds one for each cycle in which the gate has been high for at least SAT_ON consecutive earlier cycles. It clears at an enable rising edge.
- R9: The effort output, refreshed every 2^DUTY_LG cycles, equals the number of cycles in the window that just ended in which the gate was high.
- R10: The pull-in and hold measurement outputs hold the largest current sampled while in phase 1 and phase 2 respectively. Both clear at an enable rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Coil enable |
| peak_thr_i | input | CUR_W | Pull-in current target |
| hold_thr_i | input | CUR_W | Hold current target |
| peak_len_i | input | TIME_W | Maximum pull-in duration in cycles |
| cur_i | input | CUR_W | Sampled coil current |
| gate_o | output | 1 | Switch gate drive |
| fw_fast_o | output | 1 | 1 selects fast-decay path, 0 slow recirculation |
| phase_o | output | 2 | Phase code |
| oc_flag_o | output | 1 | Sticky overcurrent fault |
| peak_meas_o | output | CUR_W | Largest current in pull-in |
| hold_meas_o | output | CUR_W | Largest current in hold |
| sat_time_o | output | SAT_W | Cycles with gate pinned on |
| duty_o | output | DUTY_LG+1 | Gate-on cycles in last window |

## Verification
The bench builds the block with MIN_ON 3, MIN_OFF 2, HYST_BAND 8, SAT_ON 20 and a 32-cycle effort window. These short windows let a few hundred cycles show band-edge switching, minimum-pulse enforcement, saturation accumulation and several completed effort windows. A simple coil model, limited by a supply ceiling, makes the pull-in end both by threshold and by timeout. Forced current values probe the exact band edges and the overcurrent latch.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PEAK = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/pkh_phase_seq.sv
module pkh_phase_seq
  import pkh_pkg::*;
#(
  parameter int CUR_W    = 10,
  parameter int TIME_W   = 16,
  parameter int OC_LIMIT = 900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [CUR_W-1:0]  peak_thr_i,
  input  logic [TIME_W-1:0] peak_len_i,
  output phase_e            phase_o,
  output logic              rise_o,
  output logic              kill_o,
  output logic              oc_flag_o,
  output logic              fw_fast_o
);
  localparam logic [CUR_W-1:0] LIM = CUR_W'(OC_LIMIT);

  logic              en_q;
  phase_e            phase_q, phase_d;
  logic [TIME_W-1:0] tmr_q, tmr_d;
  logic              tmr_en;
  logic              oc_q, oc_d;
  logic              fw_q, fw_d;
  logic              over, rise, len_done;

  always_comb begin
    over     = cur_i > LIM;
    rise     = en_i & ~en_q;
    len_done = ({1'b0, tmr_q} + 1'b1) >= {1'b0, peak_len_i};
    oc_d     = (en_i & over) ? 1'b1 : (rise ? 1'b0 : oc_q);
    fw_d     = ~en_i | oc_d;
    phase_d  = phase_q;
    tmr_d    = tmr_q;
    tmr_en   = 1'b0;
    if (!en_i) begin
      phase_d = PH_IDLE;
    end else if (rise) begin
      phase_d = PH_PEAK;
      tmr_d   = '0;
      tmr_en  = 1'b1;
    end else if (phase_q == PH_PEAK) begin
      if (cur_i >= peak_thr_i || len_done) begin
        phase_d = PH_HOLD;
      end else begin
        tmr_d  = tmr_q + 1'b1;
        tmr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      oc_q    <= 1'b0;
      fw_q    <= 1'b1;
    end else begin
      en_q    <= en_i;
      phase_q <= phase_d;
      oc_q    <= oc_d;
      fw_q    <= fw_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign phase_o   = phase_q;
  assign rise_o    = rise;
  assign kill_o    = ~en_i | over | oc_q;
  assign oc_flag_o = oc_q;
  assign fw_fast_o = fw_q;

  AST_PEAK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && en_i) |=> (phase_q == PH_PEAK)); // R1
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && en_i) |=> (phase_q == PH_HOLD)); // R2
  AST_FAST_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q |-> fw_q); // R7
endmodule

// File: rtl/pkh_hyst_pwm.sv
module pkh_hyst_pwm
  import pkh_pkg::*;
#(
  parameter int CUR_W     = 10,
  parameter int MIN_ON    = 50,
  parameter int MIN_OFF   = 50,
  parameter int HYST_BAND = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic             kill_i,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [CUR_W-1:0] peak_thr_i,
  input  logic [CUR_W-1:0] hold_thr_i,
  output logic             gate_o
);
  localparam int CMAX  = (MIN_ON > MIN_OFF) ? MIN_ON : MIN_OFF;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CUR_W:0]   BAND_X = (CUR_W+1)'(HYST_BAND);
  localparam logic [CNT_W:0]   ON_X   = (CNT_W+1)'(MIN_ON);
  localparam logic [CNT_W:0]   OFF_X  = (CNT_W+1)'(MIN_OFF);
  localparam logic [CNT_W-1:0] CTOP   = CNT_W'(CMAX);

  logic             gate_q, gate_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W:0]   held;
  logic [CUR_W:0]   tgt_x, cur_x;
  logic             too_high, too_low;

  always_comb begin
    tgt_x    = {1'b0, (phase_i == PH_PEAK) ? peak_thr_i : hold_thr_i};
    cur_x    = {1'b0, cur_i};
    too_high = cur_x > (tgt_x + BAND_X);
    too_low  = (cur_x + BAND_X) < tgt_x;
    held     = {1'b0, cnt_q} + 1'b1;
    cnt_inc  = (cnt_q == CTOP) ? cnt_q : cnt_q + 1'b1;
    gate_d   = gate_q;
    cnt_d    = cnt_inc;
    if (kill_i || phase_i == PH_IDLE) begin
      gate_d = 1'b0;
      cnt_d  = gate_q ? '0 : cnt_inc;
    end else if (gate_q) begin
      if (held >= ON_X && too_high) begin
        gate_d = 1'b0;
        cnt_d  = '0;
      end
    end else begin
      if (held >= OFF_X && too_low) begin
        gate_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= CTOP;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;

  AST_GATE_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !gate_q); // R5
  AST_IDLE_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IDLE) |=> !gate_q); // R1

  generate
    if (MIN_ON >= 2) begin : g_min_on_chk
      AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |=> (gate_q || $past(kill_i))); // R4
    end
  endgenerate
endmodule

// File: rtl/pkh_stats.sv
module pkh_stats
  import pkh_pkg::*;
#(
  parameter int CUR_W   = 10,
  parameter int SAT_W   = 24,
  parameter int SAT_ON  = 400,
  parameter int DUTY_LG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               gate_i,
  input  phase_e             phase_i,
  input  logic [CUR_W-1:0]   cur_i,
  output logic [CUR_W-1:0]   peak_meas_o,
  output logic [CUR_W-1:0]   hold_meas_o,
  output logic [SAT_W-1:0]   sat_time_o,
  output logic [DUTY_LG:0]   duty_o
);
  localparam int RUN_W = $clog2(SAT_ON + 1);
  localparam logic [RUN_W-1:0]   RUN_TOP = RUN_W'(SAT_ON);
  localparam logic [DUTY_LG-1:0] WIN_END = '1;
  localparam logic [DUTY_LG:0]   WIN     = (DUTY_LG+1)'(1) << DUTY_LG;

  logic [RUN_W-1:0]   run_q, run_d;
  logic [SAT_W-1:0]   sat_q, sat_d;
  logic               sat_en;
  logic [DUTY_LG-1:0] win_q;
  logic [DUTY_LG:0]   ones_q, ones_d, duty_q, duty_d;
  logic               duty_en;
  logic [CUR_W-1:0]   pk_q, pk_d, hd_q, hd_d;
  logic               pinned;

  always_comb begin
    pinned = gate_i && (run_q == RUN_TOP);
    run_d  = gate_i ? ((run_q == RUN_TOP) ? run_q : run_q + 1'b1) : '0;
    sat_en = rise_i | (pinned & ~(&sat_q));
    sat_d  = rise_i ? '0 : sat_q + 1'b1;
    duty_en = (win_q == WIN_END);
    duty_d  = ones_q + {{DUTY_LG{1'b0}}, gate_i};
    ones_d  = duty_en ? '0 : duty_d;
    pk_d = pk_q;
    hd_d = hd_q;
    if (rise_i) begin
      pk_d = '0;
      hd_d = '0;
    end else if (phase_i == PH_PEAK && cur_i > pk_q) begin
      pk_d = cur_i;
    end else if (phase_i == PH_HOLD && cur_i > hd_q) begin
      hd_d = cur_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      sat_q  <= '0;
      win_q  <= '0;
      ones_q <= '0;
      duty_q <= '0;
      pk_q   <= '0;
      hd_q   <= '0;
    end else begin
      run_q  <= run_d;
      win_q  <= win_q + 1'b1;
      ones_q <= ones_d;
      pk_q   <= pk_d;
      hd_q   <= hd_d;
      if (sat_en)  sat_q  <= sat_d;
      if (duty_en) duty_q <= duty_d;
    end
  end

  assign peak_meas_o = pk_q;
  assign hold_meas_o = hd_q;
  assign sat_time_o  = sat_q;
  assign duty_o      = duty_q;

  AST_SAT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> (sat_q >= $past(sat_q))); // R8
  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= WIN); // R9
endmodule

// File: rtl/solenoid_pkhold_drv.sv
module solenoid_pkhold_drv
  import pkh_pkg::*;
#(
  parameter int CUR_W     = 10,
  parameter int TIME_W    = 16,
  parameter int MIN_ON    = 50,
  parameter int MIN_OFF   = 50,
  parameter int HYST_BAND = 8,
  parameter int OC_LIMIT  = 900,
  parameter int SAT_ON    = 400,
  parameter int SAT_W     = 24,
  parameter int DUTY_LG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CUR_W-1:0]  peak_thr_i,
  input  logic [CUR_W-1:0]  hold_thr_i,
  input  logic [TIME_W-1:0] peak_len_i,
  input  logic [CUR_W-1:0]  cur_i,
  output logic              gate_o,
  output logic              fw_fast_o,
  output logic [1:0]        phase_o,
  output logic              oc_flag_o,
  output logic [CUR_W-1:0]  peak_meas_o,
  output logic [CUR_W-1:0]  hold_meas_o,
  output logic [SAT_W-1:0]  sat_time_o,
  output logic [DUTY_LG:0]  duty_o
);
  phase_e phase_w;
  logic   rise_w, kill_w, gate_w, oc_w;

  pkh_phase_seq #(
    .CUR_W(CUR_W), .TIME_W(TIME_W), .OC_LIMIT(OC_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cur_i(cur_i),
    .peak_thr_i(peak_thr_i), .peak_len_i(peak_len_i),
    .phase_o(phase_w), .rise_o(rise_w), .kill_o(kill_w),
    .oc_flag_o(oc_w), .fw_fast_o(fw_fast_o)
  );

  pkh_hyst_pwm #(
    .CUR_W(CUR_W), .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF), .HYST_BAND(HYST_BAND)
  ) u_pwm (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_w), .kill_i(kill_w),
    .cur_i(cur_i), .peak_thr_i(peak_thr_i), .hold_thr_i(hold_thr_i),
    .gate_o(gate_w)
  );

  pkh_stats #(
    .CUR_W(CUR_W), .SAT_W(SAT_W), .SAT_ON(SAT_ON), .DUTY_LG(DUTY_LG)
  ) u_stats (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .gate_i(gate_w),
    .phase_i(phase_w), .cur_i(cur_i),
    .peak_meas_o(peak_meas_o), .hold_meas_o(hold_meas_o),
    .sat_time_o(sat_time_o), .duty_o(duty_o)
  );

  assign gate_o    = gate_w;
  assign oc_flag_o = oc_w;
  assign phase_o   = phase_w;

  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_w |-> !gate_w); // R6
endmodule

// File: tb/solenoid_pkhold_drv_tb_top.sv
`timescale 1ns/1ps
module solenoid_pkhold_drv_tb_top;
  localparam int CW = 10, TW = 16, MON = 3, MOFF = 2, BAND = 8, LIM = 900;
  localparam int SATON = 20, SW = 24, DLG = 5, WIN = 32, SUPPLY = 700;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [CW-1:0] pk_thr = '0, hd_thr = '0, cur = '0;
  logic [TW-1:0] plen = '0;
  logic gate_o, fw_o, oc_o;
  logic [1:0] ph_o;
  logic [CW-1:0] pkm_o, hdm_o;
  logic [SW-1:0] sat_o;
  logic [DLG:0] duty_o;

  int tests = 0, fails = 0;
  bit force_on = 0;
  int force_val = 0, plant = 0;

  // reference model state
  int m_enq, m_ph, m_tmr, m_oc, m_gate, m_cnt, m_fw, m_run, m_sat, m_win, m_ones, m_duty, m_pk, m_hd;

  always #2.5 clk = ~clk;

  solenoid_pkhold_drv #(
    .CUR_W(CW), .TIME_W(TW), .MIN_ON(MON), .MIN_OFF(MOFF), .HYST_BAND(BAND),
    .OC_LIMIT(LIM), .SAT_ON(SATON), .SAT_W(SW), .DUTY_LG(DLG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .peak_thr_i(pk_thr), .hold_thr_i(hd_thr),
    .peak_len_i(plen), .cur_i(cur), .gate_o(gate_o), .fw_fast_o(fw_o),
    .phase_o(ph_o), .oc_flag_o(oc_o), .peak_meas_o(pkm_o), .hold_meas_o(hdm_o),
    .sat_time_o(sat_o), .duty_o(duty_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_enq = 0; m_ph = 0; m_tmr = 0; m_oc = 0; m_gate = 0; m_cnt = 1000; m_fw = 1;
      m_run = 0; m_sat = 0; m_win = 0; m_ones = 0; m_duty = 0; m_pk = 0; m_hd = 0;
    end else begin
      int c, tgt, rise, ocn, kill, nph, ntmr, ng, ncnt, nrun, nsat;
      c = int'(cur); rise = (en && !m_enq) ? 1 : 0;
      ocn = (en && c > LIM) ? 1 : (rise ? 0 : m_oc);
      kill = (!en || c > LIM || m_oc) ? 1 : 0;
      nph = m_ph; ntmr = m_tmr;
      if (!en) nph = 0;
      else if (rise) begin nph = 1; ntmr = 0; end
      else if (m_ph == 1) begin
        if (c >= int'(pk_thr) || m_tmr + 1 >= int'(plen)) nph = 2; else ntmr = m_tmr + 1;
      end
      tgt = (m_ph == 1) ? int'(pk_thr) : int'(hd_thr);
      ng = m_gate; ncnt = m_cnt + 1;
      if (kill || m_ph == 0) begin ng = 0; if (m_gate) ncnt = 0; end
      else if (m_gate) begin if (m_cnt + 1 >= MON && c > tgt + BAND) begin ng = 0; ncnt = 0; end end
      else begin if (m_cnt + 1 >= MOFF && c + BAND < tgt) begin ng = 1; ncnt = 0; end end
      nrun = m_gate ? m_run + 1 : 0;
      nsat = rise ? 0 : ((m_gate && m_run >= SATON) ? m_sat + 1 : m_sat);
      if (m_win == WIN - 1) begin m_duty = m_ones + m_gate; m_ones = 0; m_win = 0; end
      else begin m_ones = m_ones + m_gate; m_win = m_win + 1; end
      if (rise) begin m_pk = 0; m_hd = 0; end
      else if (m_ph == 1 && c > m_pk) m_pk = c;
      else if (m_ph == 2 && c > m_hd) m_hd = c;
      m_fw = (!en || ocn) ? 1 : 0;
      m_enq = en; m_oc = ocn; m_ph = nph; m_tmr = ntmr; m_gate = ng; m_cnt = ncnt;
      m_run = nrun; m_sat = nsat;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 gate vs model", int'(gate_o), m_gate);
    chk("R7 fast-decay vs model", int'(fw_o), m_fw);
    chk("R1/R2 phase vs model", int'(ph_o), m_ph);
    chk("R6 fault flag vs model", int'(oc_o), m_oc);
    chk("R10 pull-in max vs model", int'(pkm_o), m_pk);
    chk("R10 hold max vs model", int'(hdm_o), m_hd);
    chk("R8 saturation vs model", int'(sat_o), m_sat);
    chk("R9 effort vs model", int'(duty_o), m_duty);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (force_on) plant = force_val;
      else begin
        if (gate_o) plant = (plant + 12 > SUPPLY) ? SUPPLY : plant + 12;
        else plant = plant - (fw_o ? 20 : 3);
        if (plant < 0) plant = 0;
      end
      cur = CW'(plant);
    end
  endtask

  task automatic set_cur(input int v);
    force_on = 1; force_val = v; plant = v; cur = CW'(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, tog, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(2);
    // R1 R7: reset state
    chk("R1 reset phase", int'(ph_o), 0);
    chk("R7 reset fast-decay", int'(fw_o), 1);
    chk("R3 reset gate", int'(gate_o), 0);

    // pull-in ended by threshold
    pk_thr = 10'd400; hd_thr = 10'd150; plen = 16'd200; en = 1'b1;
    step(1);
    chk("R1 phase after enable", int'(ph_o), 1);
    chk("R1 gate low at enable edge", int'(gate_o), 0);
    k = 0;
    while (ph_o == 2'd1 && k < 250) begin step(1); k++; end
    chk("R2 early end by threshold", int'(k < 200), 1);
    chk("R10 pull-in max reached threshold", int'(pkm_o >= 400), 1);
    tog = 0; prev = gate_o;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (int'(gate_o) != prev) tog++;
      prev = gate_o;
    end
    chk("R3 gate regulates in hold", int'(tog > 4), 1);
    chk("R7 slow path while running", int'(fw_o), 0);
    chk("R10 hold max above target", int'(hdm_o > 150), 1);

    // disable
    en = 1'b0;
    step(1);
    chk("R5 gate off on disable", int'(gate_o), 0);
    chk("R5 phase idle on disable", int'(ph_o), 0);
    chk("R7 fast path on disable", int'(fw_o), 1);
    step(40);

    // pull-in ended by timeout, saturated drive
    pk_thr = 10'd1000; plen = 16'd50; en = 1'b1;
    step(1);
    k = 0;
    while (ph_o == 2'd1 && k < 100) begin k++; step(1); end
    chk("R2 timed pull-in length", k, 50);
    chk("R8 saturation accumulated", int'(sat_o > 0), 1);
    en = 1'b0;
    step(50);

    // band edges and minimum times
    pk_thr = 10'd200; plen = 16'd5; hd_thr = 10'd150;
    set_cur(100); en = 1'b1;
    step(10);
    chk("R2 hold after short pull-in", int'(ph_o), 2);
    chk("R3 gate on below band", int'(gate_o), 1);
    set_cur(158);
    for (int i = 0; i < 4; i++) begin step(1); chk("R3 upper band edge holds", int'(gate_o), 1); end
    set_cur(159);
    step(1);
    chk("R3 gate off above band", int'(gate_o), 0);
    set_cur(142);
    for (int i = 0; i < 4; i++) begin step(1); chk("R3 lower band edge holds", int'(gate_o), 0); end
    set_cur(141);
    step(1);
    chk("R3 gate on below band", int'(gate_o), 1);
    set_cur(200);
    step(1); chk("R4 min on cycle 2", int'(gate_o), 1);
    step(1); chk("R4 min on cycle 3", int'(gate_o), 1);
    step(1); chk("R4 off after min on", int'(gate_o), 0);

    // full effort window
    set_cur(100);
    step(80);
    chk("R9 full window effort", int'(duty_o), WIN);

    // overcurrent latch
    set_cur(950);
    step(1);
    chk("R6 gate off on overcurrent", int'(gate_o), 0);
    chk("R6 fault set", int'(oc_o), 1);
    chk("R7 fast path on fault", int'(fw_o), 1);
    set_cur(100);
    k = 0;
    for (int i = 0; i < 30; i++) begin step(1); k += int'(gate_o); end
    chk("R6 gate blocked while faulted", k, 0);
    en = 1'b0;
    step(5);
    chk("R6 fault held while disabled", int'(oc_o), 1);
    en = 1'b1;
    step(1);
    chk("R6 fault cleared on enable edge", int'(oc_o), 0);
    chk("R1 pull-in after re-enable", int'(ph_o), 1);
    step(40);
    en = 1'b0;
    step(70);
    chk("R9 idle window effort", int'(duty_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule